// File: doc/BRIEF.md
# Dual-Channel Memory Address Mapper

This block sits at the front of a memory controller that drives one or two channels, each 64 data bits wide. It takes a flat physical byte address and works out which channel serves it and the address inside that channel. An 8-beat burst on a 64-bit channel moves one 64-byte line, so all mapping is done at 64-byte line granularity.

Three organizations are chosen at run time by a configuration input. Single mode sends everything to channel A. Stacked mode fills channel A completely, and channel B follows it in the address space. Interleaved mode alternates channels on every 64-byte line. Channel sizes are configured in units of 64-byte lines.

Each request enters through a valid/ready handshake. Its translation is captured in one register stage, which presents the channel select, the local address and a range-error flag under a valid/ready handshake of its own.

Top module: `dual_chan_addr_map`

## Requirements
- R1: A request accepted while `in_valid` and `in_ready` are high appears on the outputs with `out_valid` high on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R2: While `rst_n` is low at a clock edge, the stage empties: `out_valid` is 0 and `in_ready` is 1 after that edge.
- R3: Single mode is `cfg_mode` = 0. An address below `cfg_lines_a`×64 selects channel A, and the local address equals the input address.
- R4: Stacked mode is `cfg_mode` = 1. An address below `cfg_lines_a`×64 selects channel A, and the local address equals the input address.
- R5: In stacked mode, an address at or above `cfg_lines_a`×64 and below (`cfg_lines_a`+`cfg_lines_b`)×64 selects channel B. Its local address is the input address minus `cfg_lines_a`×64.
- R6: Interleaved mode is `cfg_mode` = 2. For an in-range address, address bit 6 selects the channel (0 gives A, 1 gives B). The local address is the input address with bit 6 removed: bits 5:0 are kept, the upper bits move down by one place, and the top bit is 0.
- R7: The address limit is `cfg_lines_a`×64 in single mode and (`cfg_lines_a`+`cfg_lines_b`)×64 otherwise. An address at or beyond the limit gives `out_err` = 1, `out_sel` = 00 and `out_local` = 0.
- R8: `cfg_err` is 1 when `cfg_mode` = 2 and the two sizes differ, or when `cfg_mode` = 3 (reserved). A request accepted while `cfg_err` is 1 returns `out_err` = 1 with no channel selected.
- R9: `out_sel` bit 0 means channel A and bit 1 means channel B. At most one bit is set while `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Organization: 0 single, 1 stacked, 2 interleaved, 3 reserved |
| cfg_lines_a | input | SZ_W | Channel A size in 64-byte lines |
| cfg_lines_b | input | SZ_W | Channel B size in 64-byte lines |
| cfg_err | output | 1 | Configuration is inconsistent |
| in_valid | input | 1 | Request address is valid |
| in_ready | output | 1 | Request can be accepted |
| in_addr | input | ADDR_W | Physical byte address |
| out_valid | output | 1 | Translation result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sel | output | 2 | Channel select, bit 0 = A, bit 1 = B |
| out_local | output | ADDR_W | Channel-local byte address |
| out_err | output | 1 | Address out of range or configuration error |

## Verification
Acceptance of a new request and removal of the held result can fall in the same cycle. That happens when `out_ready` rises while a stalled result is held and `in_valid` is high. The register must then replace the old result with the new one, with no gap and no duplicate. The bench provokes this with long stalls released under continuous traffic, including configuration changes while a result is held. A behavioural queue model predicts, on every cycle, the occupancy, the ready signal and the result fields, and the bench compares them.

// File: rtl/amap_pkg.sv
// Package: shared mode encoding for the address mapper.
// Assumes the mode code is two bits wide; code 3 is reserved.
package amap_pkg;
    typedef enum logic [1:0] {
        MAP_SINGLE  = 2'd0,
        MAP_STACKED = 2'd1,
        MAP_INTERLV = 2'd2,
        MAP_RSVD    = 2'd3
    } map_mode_e;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_A    = 2'b01;
    localparam logic [1:0] SEL_B    = 2'b10;
endpackage

// File: rtl/amap_cfg_check.sv
// Module: validates the organization settings and derives the line limit.
// Assumes sizes are in line units; the limit is one bit wider than a size.
module amap_cfg_check
    import amap_pkg::*;
#(
    parameter int SZ_W = 27
) (
    input  logic [1:0]      mode,
    input  logic [SZ_W-1:0] lines_a,
    input  logic [SZ_W-1:0] lines_b,
    output logic            bad_cfg,
    output logic [SZ_W:0]   limit_lines
);
    // Purpose: flag a reserved code or unequal sizes in interleaved mode.
    always_comb begin
        unique case (map_mode_e'(mode))
            MAP_INTERLV: bad_cfg = (lines_a != lines_b);
            MAP_RSVD:    bad_cfg = 1'b1;
            default:     bad_cfg = 1'b0;
        endcase
    end

    // Purpose: total number of lines the current organization reaches.
    always_comb begin
        if (map_mode_e'(mode) == MAP_SINGLE)
            limit_lines = {1'b0, lines_a};
        else
            limit_lines = {1'b0, lines_a} + {1'b0, lines_b};
    end
endmodule

// File: rtl/amap_translate.sv
// Module: combinational translation of one byte address to channel and
// local address. Assumes LINE_OFS < ADDR_W-1 and a pre-checked config.
module amap_translate
    import amap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 6,
    parameter int SZ_W     = ADDR_W - LINE_OFS + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        mode,
    input  logic [SZ_W-1:0]   lines_a,
    input  logic [SZ_W:0]     limit_lines,
    input  logic              bad_cfg,
    output logic [1:0]        sel,
    output logic [ADDR_W-1:0] local_addr,
    output logic              err
);
    localparam int IDX_W = ADDR_W - LINE_OFS;
    localparam int PAD_W = SZ_W + 1 - IDX_W;

    logic [SZ_W:0]     line_idx;
    logic              beyond;
    logic              in_upper;
    logic [ADDR_W-1:0] stack_b_addr;
    logic [ADDR_W-1:0] ilv_addr;

    // Purpose: line index of the address, widened to match the limit.
    always_comb line_idx = {{PAD_W{1'b0}}, addr[ADDR_W-1:LINE_OFS]};

    // Purpose: range test and stacked-region test on line indices.
    always_comb begin
        beyond   = (line_idx >= limit_lines);
        in_upper = (line_idx >= {1'b0, lines_a});
    end

    // Purpose: channel B offset in stacked mode.
    always_comb stack_b_addr = addr - {lines_a[SZ_W-2:0], {LINE_OFS{1'b0}}};

    // Purpose: interleaved local address with the select bit squeezed out.
    always_comb ilv_addr = {1'b0, addr[ADDR_W-1:LINE_OFS+1], addr[LINE_OFS-1:0]};

    // Purpose: choose select and local address for the configured mode.
    always_comb begin
        sel        = SEL_NONE;
        local_addr = '0;
        err        = 1'b0;
        if (bad_cfg || beyond) begin
            err = 1'b1;
        end else begin
            unique case (map_mode_e'(mode))
                MAP_STACKED: begin
                    sel        = in_upper ? SEL_B : SEL_A;
                    local_addr = in_upper ? stack_b_addr : addr;
                end
                MAP_INTERLV: begin
                    sel        = addr[LINE_OFS] ? SEL_B : SEL_A;
                    local_addr = ilv_addr;
                end
                default: begin
                    sel        = SEL_A;
                    local_addr = addr;
                end
            endcase
        end
    end
endmodule

// File: rtl/amap_stage.sv
// Module: one register slice with valid/ready on both sides.
// Assumes the upstream holds data stable while valid and not ready.
module amap_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [DW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [DW-1:0] dn_data
);
    // Purpose: slot accepts when empty or being drained this cycle.
    always_comb up_ready = !dn_valid || dn_ready;

    // Purpose: capture accepted data, drop a drained result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
            if (up_valid)
                dn_data <= up_data;
        end
    end
endmodule

// File: rtl/dual_chan_addr_map.sv
// Module: top of the dual-channel address mapper. Checks the config,
// translates the address and registers the result once.
// Assumes lines of LINE_BYTES (power of two) and sizes in line units.
module dual_chan_addr_map #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SZ_W       = ADDR_W - $clog2(LINE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [SZ_W-1:0]   cfg_lines_a,
    input  logic [SZ_W-1:0]   cfg_lines_b,
    output logic              cfg_err,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_sel,
    output logic [ADDR_W-1:0] out_local,
    output logic              out_err
);
    localparam int LINE_OFS = $clog2(LINE_BYTES);
    localparam int RES_W    = 2 + ADDR_W + 1;

    logic [SZ_W:0]     limit_lines;
    logic [1:0]        t_sel;
    logic [ADDR_W-1:0] t_local;
    logic              t_err;
    logic [RES_W-1:0]  res_q;

    amap_cfg_check #(.SZ_W(SZ_W)) u_cfg (
        .mode        (cfg_mode),
        .lines_a     (cfg_lines_a),
        .lines_b     (cfg_lines_b),
        .bad_cfg     (cfg_err),
        .limit_lines (limit_lines)
    );

    amap_translate #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .SZ_W(SZ_W)) u_xlat (
        .addr        (in_addr),
        .mode        (cfg_mode),
        .lines_a     (cfg_lines_a),
        .limit_lines (limit_lines),
        .bad_cfg     (cfg_err),
        .sel         (t_sel),
        .local_addr  (t_local),
        .err         (t_err)
    );

    amap_stage #(.DW(RES_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  ({t_sel, t_local, t_err}),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (res_q)
    );

    // Purpose: split the registered result into output fields.
    always_comb {out_sel, out_local, out_err} = res_q;
endmodule

// File: rtl/amap_checker.sv
// Module: protocol and mapping properties, bound to the top module.
module amap_checker #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFS = 6,
    parameter int SZ_W     = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [SZ_W-1:0]   cfg_lines_a,
    input logic [SZ_W-1:0]   cfg_lines_b,
    input logic              cfg_err,
    input logic              in_valid,
    input logic              in_ready,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_sel,
    input logic [ADDR_W-1:0] out_local,
    input logic              out_err
);
    logic [ADDR_W:0] idx;
    logic [ADDR_W:0] sz_a;
    logic [ADDR_W:0] sz_ab;
    assign idx   = {1'b0, in_addr} >> LINE_OFS;
    assign sz_a  = (ADDR_W+1)'(cfg_lines_a);
    assign sz_ab = (ADDR_W+1)'(cfg_lines_a) + (ADDR_W+1)'(cfg_lines_b);

    assert_reset_idle_R2: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_sel)
            && $stable(out_local) && $stable(out_err));

    assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(out_sel));

    assert_err_no_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_sel == 2'b00 && out_local == '0);

    assert_single_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_mode == 2'd0 && idx < sz_a
        |=> out_sel == 2'b01 && out_local == $past(in_addr) && !out_err);

    assert_ilv_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_mode == 2'd2 && !cfg_err && idx < sz_ab
        |=> out_sel == ($past(in_addr[LINE_OFS]) ? 2'b10 : 2'b01));

    assert_cfg_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && cfg_err |=> out_err);
endmodule

bind dual_chan_addr_map amap_checker #(
    .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .SZ_W(SZ_W)
) u_amap_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_lines_a(cfg_lines_a), .cfg_lines_b(cfg_lines_b), .cfg_err(cfg_err),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
    .out_local(out_local), .out_err(out_err)
);

// File: tb/dual_chan_addr_map_test.sv
`timescale 1ns/1ps
module dual_chan_addr_map_test;
    localparam int ADDR_W = 32;
    localparam int SZ_W   = 27;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n;
    logic [1:0]        cfg_mode;
    logic [SZ_W-1:0]   cfg_lines_a, cfg_lines_b;
    logic              cfg_err;
    logic              in_valid, in_ready;
    logic [ADDR_W-1:0] in_addr;
    logic              out_valid, out_ready;
    logic [1:0]        out_sel;
    logic [ADDR_W-1:0] out_local;
    logic              out_err;

    dual_chan_addr_map uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .cfg_lines_a(cfg_lines_a), .cfg_lines_b(cfg_lines_b), .cfg_err(cfg_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_sel(out_sel),
        .out_local(out_local), .out_err(out_err)
    );

    typedef struct {
        logic [1:0]  sel;
        logic [31:0] loc;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // Expected translation, worked out from the requirements.
    function automatic exp_t model(input logic [31:0] a, input int m, input int la, input int lb);
        exp_t e;
        longint ad = longint'(a);
        longint sa = longint'(la) * 64;
        longint sb = longint'(lb) * 64;
        e.sel = 2'b00; e.loc = '0; e.err = 1'b1;
        if (m == 3)                      e.tag = "R8";
        else if (m == 2 && la != lb)     e.tag = "R8";
        else if (m == 0 && ad >= sa)     e.tag = "R7";
        else if (m != 0 && ad >= sa + sb) e.tag = "R7";
        else begin
            e.err = 1'b0;
            if (m == 0) begin
                e.tag = "R3"; e.sel = 2'b01; e.loc = a;
            end else if (m == 1 && ad < sa) begin
                e.tag = "R4"; e.sel = 2'b01; e.loc = a;
            end else if (m == 1) begin
                e.tag = "R5"; e.sel = 2'b10; e.loc = 32'(ad - sa);
            end else begin
                e.tag = "R6"; e.sel = a[6] ? 2'b10 : 2'b01;
                e.loc = 32'((ad / 128) * 64 + (ad % 64));
            end
        end
        return e;
    endfunction

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Compare the ports with the model state; called away from the edge.
    task automatic compare();
        bit exp_bad;
        check("R1", "out_valid", longint'(out_valid), longint'(q.size() != 0));
        check("R1", "in_ready", longint'(in_ready), longint'(q.size() == 0 || out_ready));
        exp_bad = (cfg_mode == 2'd3) || (cfg_mode == 2'd2 && cfg_lines_a != cfg_lines_b);
        check("R8", "cfg_err", longint'(cfg_err), longint'(exp_bad));
        if (q.size() != 0) begin
            check(q[0].tag, "out_sel", longint'(out_sel), longint'(q[0].sel));
            check(q[0].tag, "out_local", longint'(out_local), longint'(q[0].loc));
            check(q[0].tag, "out_err", longint'(out_err), longint'(q[0].err));
            check("R9", "sel_onehot0", longint'($countones(out_sel) <= 1), 1);
        end
    endtask

    // One cycle: drive at negedge, step the model across the edge, compare.
    task automatic cyc(input bit v, input logic [31:0] a, input bit rdy);
        bit fire;
        exp_t e;
        in_valid = v; in_addr = a; out_ready = rdy;
        fire = v && (q.size() == 0 || rdy);
        e = model(a, int'(cfg_mode), int'(cfg_lines_a), int'(cfg_lines_b));
        @(posedge clk);
        if (rdy && q.size() != 0) void'(q.pop_front());
        if (fire) q.push_back(e);
        @(negedge clk);
        compare();
    endtask

    task automatic set_cfg(input int m, input int la, input int lb);
        cfg_mode = 2'(m); cfg_lines_a = SZ_W'(la); cfg_lines_b = SZ_W'(lb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; out_ready = 1'b1;
        set_cfg(0, 16, 16);
        repeat (3) @(negedge clk);
        check("R2", "out_valid in reset", longint'(out_valid), 0);
        check("R2", "in_ready in reset", longint'(in_ready), 1);
        rst_n = 1'b1;

        // R3 single mode and its limit (R7)
        set_cfg(0, 16, 16);
        cyc(1, 32'h000, 1); cyc(1, 32'h3FF, 1); cyc(1, 32'h400, 1); cyc(1, 32'h7C0, 1);
        // R4 / R5 stacked, boundary at size A and at A+B (R7)
        set_cfg(1, 16, 8);
        cyc(1, 32'h3FF, 1); cyc(1, 32'h400, 1); cyc(1, 32'h5FF, 1); cyc(1, 32'h600, 1);
        // R6 interleaved, alternating lines and the top line
        set_cfg(2, 16, 16);
        cyc(1, 32'h000, 1); cyc(1, 32'h040, 1); cyc(1, 32'h07F, 1);
        cyc(1, 32'h080, 1); cyc(1, 32'h7FF, 1); cyc(1, 32'h800, 1);
        // R8 unequal sizes and reserved code
        set_cfg(2, 16, 8);
        cyc(1, 32'h040, 1);
        set_cfg(3, 16, 16);
        cyc(1, 32'h000, 1);
        // R1 stall with config changes, then release under traffic
        set_cfg(1, 16, 8);
        cyc(1, 32'h480, 0);
        set_cfg(2, 16, 16);
        cyc(1, 32'h0C0, 0); cyc(1, 32'h0C0, 0); cyc(1, 32'h0C0, 1); cyc(0, 32'h0, 0);
        cyc(0, 32'h0, 1);
        // Mixed traffic across all modes
        for (int i = 0; i < 600; i++) begin
            if (i % 40 == 0) begin
                int m  = int'($urandom_range(0, 3));
                int la = 8 * int'($urandom_range(1, 3));
                int lb = ($urandom_range(0, 1) != 0) ? la : 8 * int'($urandom_range(1, 3));
                set_cfg(m, la, lb);
            end
            cyc(bit'($urandom_range(0, 3) != 0), 32'($urandom_range(0, 4095)),
                bit'($urandom_range(0, 2) != 0));
        end
        cyc(0, 32'h0, 1);
        done = 1;
        summary();
        $finish;
    end
endmodule